// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits behind the bus write port of a NOR-style flash device. It watches the active-low write-enable and chip-enable strobes. It takes the address and data byte of each bus write as it completes, decodes the byte as a command, and follows the command through its multi-cycle setup/confirm sequence. It keeps the read mode that selects which data a read returns: the memory array, the identifier codes, the query table or the status byte. It also holds the status error flags and a small configuration register for the busy pin.

Operations that need the erase/program engine are handed over as one-cycle start pulses, each carrying the captured address and data. Those operations are block erase, chip erase, single write, buffered multi-write (one load pulse per data cycle plus a final start), lock-bit set, lock-bit clear, suspend and resume. The engine itself sits outside this block and reports back only through a busy input. Per-block lock bits are kept here. Erase and write requests aimed at a locked block are refused unless the write-protect override input is high.

Top module: `flash_cmd_seq`

## Requirements
- R1: After a synchronous active-low reset, the outputs are as follows. `rd_mode` is 0 (array). The error bits of `status` are clear. `busy_cfg` is 0. No start pulse is high. All lock bits are clear. The `rd_mode` encoding is 0 array, 1 identifier, 2 query, 3 status.
- R2: In idle, a command byte sets the read mode. FFh selects array, 90h selects identifier, 98h selects query and 70h selects status. A byte that is no defined command leaves the read mode, the status byte and the configuration register unchanged.
- R3: The `status` byte has this layout. Bit 7 is ready (the inverse of `eng_busy`). Bit 6 is suspended. Bit 5 is erase error, bit 4 is program error and bit 1 is protect error. All other bits are 0. Command 50h clears bits 5, 4 and 1 and leaves the read mode unchanged.
- R4: 20h followed by D0h raises `go_blk_erase` for one cycle, with `cmd_addr` set to the confirm cycle's address. The setup cycle switches the read mode to status.
- R5: 30h followed by D0h raises `go_chip_erase`. When any lock bit is set and `wp_ok` is low, the request is refused instead and bits 5 and 1 are set.
- R6: 40h and 10h are equivalent single-write setups. The next bus write raises `go_write`, with `cmd_addr`/`cmd_data` taken from that cycle, whatever its data value.
- R7: A buffered write is E8h, then a count N (1 to BUF_WORDS), then N data cycles, then D0h. Each data cycle raises `go_buf_load` with its address and data. The confirm raises `go_multi`. A count of 0 or above BUF_WORDS aborts as in R11.
- R8: B0h while `eng_busy` is high and the engine is not suspended raises `go_suspend` and sets status bit 6. D0h in idle while suspended raises `go_resume` and clears bit 6. B0h at any other time is ignored.
- R9: 60h then 01h raises `go_lock_set` and locks the block given by the top address bits (addr[20:16] by default). 60h then D0h raises `go_lock_clr` and clears every lock bit, but only when `wp_ok` is high. Otherwise no pulse is raised and bits 5 and 1 are set.
- R10: A block erase, single write or buffered write that touches a locked block while `wp_ok` is low raises no start pulse. It sets bit 1 and also bit 5 (erase) or bit 4 (write).
- R11: When the second cycle of a two-cycle command does not carry its expected code, the sequence returns to idle. Bits 5 and 4 are set, the read mode becomes status, and no pulse is raised.
- R12: B8h followed by 00h to 03h loads that value into `busy_cfg`, without changing the read mode. Any other second byte aborts as in R11.
- R13: A bus write completes on the first rising edge of either strobe after both were low. Address and data come from the last clock in which both strobes were low. Each completed write produces at most one start pulse, which lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we_n | input | 1 | Write-enable strobe, active low |
| bus_ce_n | input | 1 | Chip-enable strobe, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | 8 | Bus data byte |
| wp_ok | input | 1 | Write-protect override; high permits locked-block operations and lock clearing |
| eng_busy | input | 1 | Erase/program engine is running |
| rd_mode | output | 2 | Read mode: 0 array, 1 identifier, 2 query, 3 status |
| status | output | 8 | Status byte |
| busy_cfg | output | 2 | Busy-pin mode configuration |
| go_blk_erase | output | 1 | Block erase start pulse |
| go_chip_erase | output | 1 | Chip erase start pulse |
| go_write | output | 1 | Single write start pulse |
| go_buf_load | output | 1 | Buffered write data load pulse |
| go_multi | output | 1 | Buffered write start pulse |
| go_lock_set | output | 1 | Lock-bit set pulse |
| go_lock_clr | output | 1 | Lock-bit clear-all pulse |
| go_suspend | output | 1 | Suspend pulse |
| go_resume | output | 1 | Resume pulse |
| cmd_addr | output | ADDR_W | Address for the current pulse |
| cmd_data | output | 8 | Data for the current pulse |

## Verification
Directed sequences cover each valid command pair and a wrong confirm byte after every setup code. They also cover buffered counts of 0, within range and too large. Writes to locked blocks are made with the override both low and high, which separates refusal from acceptance. A long random byte stream follows, drawn from opcodes, small counts and arbitrary values, with random override, busy and address inputs. This stream reaches sequences that were never planned, such as a command code arriving as write data or a suspend while idle. Two strobe variants separate the two capture rules: one releases chip enable before write enable, and one changes the address during a long low phase.

// File: rtl/fcs_pkg.sv
// Package: shared command codes, read-mode and sequence types for the
// flash command sequencer. Assumes 8-bit command bytes.
package fcs_pkg;

    localparam logic [7:0] OP_ARRAY   = 8'hFF;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_QUERY   = 8'h98;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_CLRSTAT = 8'h50;
    localparam logic [7:0] OP_BERASE  = 8'h20;
    localparam logic [7:0] OP_CERASE  = 8'h30;
    localparam logic [7:0] OP_WRITE_A = 8'h40;
    localparam logic [7:0] OP_WRITE_B = 8'h10;
    localparam logic [7:0] OP_BUFWR   = 8'hE8;
    localparam logic [7:0] OP_SUSPEND = 8'hB0;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_LOCK    = 8'h60;
    localparam logic [7:0] OP_LOCKSET = 8'h01;
    localparam logic [7:0] OP_CONFIG  = 8'hB8;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_QUERY  = 2'd2,
        RM_STATUS = 2'd3
    } rd_mode_e;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_BLK, SQ_CHIP, SQ_WORD, SQ_MCNT,
        SQ_MDAT, SQ_MCONF, SQ_LOCK, SQ_CFG
    } seq_e;

    typedef struct packed {
        logic blk;
        logic chip;
        logic word;
        logic load;
        logic multi;
        logic lset;
        logic lclr;
        logic susp;
        logic resume;
    } go_t;

endpackage

// File: rtl/fcs_strobe.sv
// Bus write capture. A write is active while both strobes are low; it
// completes when either strobe rises. Address/data of the last active
// clock are presented with a one-cycle completion pulse.
// Assumes the strobes are already synchronous to clk.
module fcs_strobe #(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              stb,
    output logic [ADDR_W-1:0] s_addr,
    output logic [7:0]        s_data
);
    logic              act;
    logic              act_q;
    logic [ADDR_W-1:0] cap_addr;
    logic [7:0]        cap_data;

    assign act = ~we_n & ~ce_n;

    // Track the active phase, hold its last address/data, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            stb      <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
            s_addr   <= '0;
            s_data   <= '0;
        end else begin
            act_q <= act;
            stb   <= act_q & ~act;
            if (act) begin
                cap_addr <= addr;
                cap_data <= data;
            end
            if (act_q & ~act) begin
                s_addr <= cap_addr;
                s_data <= cap_data;
            end
        end
    end
endmodule

// File: rtl/fcs_lock.sv
// Per-block lock bits. Set one bit by index, clear all at once, and
// report the lock state of a queried block plus whether any bit is set.
// Assumes NUM_BLOCKS is a power of two.
module fcs_lock #(
    parameter int NUM_BLOCKS = 32,
    parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [BLK_W-1:0] set_idx,
    input  logic             clr_all,
    input  logic [BLK_W-1:0] chk_idx,
    output logic             locked,
    output logic             any_locked
);
    logic [NUM_BLOCKS-1:0] bits;

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_bit
        logic lk_q;
        // One lock flag: cleared by reset or clear-all, set when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   lk_q <= 1'b0;
            else if (clr_all)                             lk_q <= 1'b0;
            else if (set_en && set_idx == BLK_W'(b))      lk_q <= 1'b1;
        end
        assign bits[b] = lk_q;
    end

    assign locked     = bits[chk_idx];
    assign any_locked = |bits;
endmodule

// File: rtl/fcs_decoder.sv
// Command decoder and sequence tracker. Consumes completed bus writes,
// keeps read mode, error flags, suspend flag and busy-pin config, and
// issues registered one-cycle start pulses. Lock state comes from
// fcs_lock; lock updates are requested combinationally on the pulse edge.
module fcs_decoder
    import fcs_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int BUF_WORDS = 16,
    parameter int CNT_W     = $clog2(BUF_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [7:0]        s_data,
    input  logic              wp_ok,
    input  logic              eng_busy,
    input  logic              locked,
    input  logic              any_locked,
    output logic              lk_set,
    output logic              lk_clr,
    output rd_mode_e          mode,
    output logic [7:0]        status,
    output logic [1:0]        cfg,
    output go_t               go,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data
);
    seq_e             state;
    logic             err_e, err_p, err_x, susp, refused;
    logic [CNT_W-1:0] cnt;
    logic             blocked;

    assign blocked = locked & ~wp_ok;
    assign lk_set  = stb && state == SQ_LOCK && s_data == OP_LOCKSET;
    assign lk_clr  = stb && state == SQ_LOCK && s_data == OP_CONFIRM && wp_ok;
    assign status  = {~eng_busy, susp, err_e, err_p, 2'b00, err_x, 1'b0};

    // Sequence state machine: one decision per completed bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            mode     <= RM_ARRAY;
            err_e    <= 1'b0;
            err_p    <= 1'b0;
            err_x    <= 1'b0;
            susp     <= 1'b0;
            refused  <= 1'b0;
            cnt      <= '0;
            cfg      <= 2'd0;
            go       <= '0;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else begin
            go <= '0;
            if (stb) begin
                case (state)
                    SQ_IDLE: begin
                        case (s_data)
                            OP_ARRAY:   mode <= RM_ARRAY;
                            OP_IDENT:   mode <= RM_IDENT;
                            OP_QUERY:   mode <= RM_QUERY;
                            OP_STATUS:  mode <= RM_STATUS;
                            OP_CLRSTAT: begin err_e <= 1'b0; err_p <= 1'b0; err_x <= 1'b0; end
                            OP_BERASE:  begin state <= SQ_BLK;  mode <= RM_STATUS; end
                            OP_CERASE:  begin state <= SQ_CHIP; mode <= RM_STATUS; end
                            OP_WRITE_A,
                            OP_WRITE_B: begin state <= SQ_WORD; mode <= RM_STATUS; end
                            OP_BUFWR:   begin state <= SQ_MCNT; mode <= RM_STATUS; end
                            OP_LOCK:    begin state <= SQ_LOCK; mode <= RM_STATUS; end
                            OP_CONFIG:  state <= SQ_CFG;
                            OP_SUSPEND: if (eng_busy && !susp) begin
                                go.susp <= 1'b1; susp <= 1'b1; mode <= RM_STATUS;
                            end
                            OP_CONFIRM: if (susp) begin
                                go.resume <= 1'b1; susp <= 1'b0; mode <= RM_STATUS;
                            end
                            default: ;
                        endcase
                    end
                    SQ_BLK: begin
                        state <= SQ_IDLE;
                        if (s_data != OP_CONFIRM) begin
                            err_e <= 1'b1; err_p <= 1'b1; mode <= RM_STATUS;
                        end else if (blocked) begin
                            err_e <= 1'b1; err_x <= 1'b1;
                        end else begin
                            go.blk <= 1'b1; cmd_addr <= s_addr;
                        end
                    end
                    SQ_CHIP: begin
                        state <= SQ_IDLE;
                        if (s_data != OP_CONFIRM) begin
                            err_e <= 1'b1; err_p <= 1'b1; mode <= RM_STATUS;
                        end else if (any_locked && !wp_ok) begin
                            err_e <= 1'b1; err_x <= 1'b1;
                        end else begin
                            go.chip <= 1'b1;
                        end
                    end
                    SQ_WORD: begin
                        state <= SQ_IDLE;
                        if (blocked) begin
                            err_p <= 1'b1; err_x <= 1'b1;
                        end else begin
                            go.word <= 1'b1; cmd_addr <= s_addr; cmd_data <= s_data;
                        end
                    end
                    SQ_MCNT: begin
                        if (s_data == 8'd0 || int'(s_data) > BUF_WORDS) begin
                            state <= SQ_IDLE;
                            err_e <= 1'b1; err_p <= 1'b1; mode <= RM_STATUS;
                        end else begin
                            state   <= SQ_MDAT;
                            cnt     <= s_data[CNT_W-1:0];
                            refused <= 1'b0;
                        end
                    end
                    SQ_MDAT: begin
                        go.load  <= 1'b1;
                        cmd_addr <= s_addr;
                        cmd_data <= s_data;
                        if (blocked) refused <= 1'b1;
                        cnt <= cnt - 1'b1;
                        if (cnt == CNT_W'(1)) state <= SQ_MCONF;
                    end
                    SQ_MCONF: begin
                        state <= SQ_IDLE;
                        if (s_data != OP_CONFIRM) begin
                            err_e <= 1'b1; err_p <= 1'b1; mode <= RM_STATUS;
                        end else if (refused) begin
                            err_p <= 1'b1; err_x <= 1'b1;
                        end else begin
                            go.multi <= 1'b1;
                        end
                    end
                    SQ_LOCK: begin
                        state <= SQ_IDLE;
                        if (s_data == OP_LOCKSET) begin
                            go.lset <= 1'b1; cmd_addr <= s_addr;
                        end else if (s_data == OP_CONFIRM) begin
                            if (wp_ok) go.lclr <= 1'b1;
                            else begin err_e <= 1'b1; err_x <= 1'b1; end
                        end else begin
                            err_e <= 1'b1; err_p <= 1'b1; mode <= RM_STATUS;
                        end
                    end
                    SQ_CFG: begin
                        state <= SQ_IDLE;
                        if (s_data < 8'd4) cfg <= s_data[1:0];
                        else begin
                            err_e <= 1'b1; err_p <= 1'b1; mode <= RM_STATUS;
                        end
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
// Top of the flash command sequencer: bus write capture, lock bits and
// command decoder. Start pulses are registered; the status ready bit
// follows eng_busy combinationally.
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int NUM_BLOCKS = 32,
    parameter int BUF_WORDS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we_n,
    input  logic              bus_ce_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_data,
    input  logic              wp_ok,
    input  logic              eng_busy,
    output logic [1:0]        rd_mode,
    output logic [7:0]        status,
    output logic [1:0]        busy_cfg,
    output logic              go_blk_erase,
    output logic              go_chip_erase,
    output logic              go_write,
    output logic              go_buf_load,
    output logic              go_multi,
    output logic              go_lock_set,
    output logic              go_lock_clr,
    output logic              go_suspend,
    output logic              go_resume,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data
);
    localparam int BLK_W = $clog2(NUM_BLOCKS);

    logic              stb, lk_set, lk_clr, locked, any_locked;
    logic [ADDR_W-1:0] s_addr;
    logic [7:0]        s_data;
    logic [BLK_W-1:0]  blk_idx;
    rd_mode_e          mode;
    go_t               go;

    assign blk_idx = s_addr[ADDR_W-1 -: BLK_W];

    fcs_strobe #(.ADDR_W(ADDR_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .we_n(bus_we_n), .ce_n(bus_ce_n),
        .addr(bus_addr), .data(bus_data),
        .stb(stb), .s_addr(s_addr), .s_data(s_data)
    );

    fcs_lock #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .set_en(lk_set), .set_idx(blk_idx),
        .clr_all(lk_clr), .chk_idx(blk_idx),
        .locked(locked), .any_locked(any_locked)
    );

    fcs_decoder #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS)) u_dec (
        .clk(clk), .rst_n(rst_n), .stb(stb), .s_addr(s_addr), .s_data(s_data),
        .wp_ok(wp_ok), .eng_busy(eng_busy), .locked(locked),
        .any_locked(any_locked), .lk_set(lk_set), .lk_clr(lk_clr),
        .mode(mode), .status(status), .cfg(busy_cfg), .go(go),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    assign rd_mode       = mode;
    assign go_blk_erase  = go.blk;
    assign go_chip_erase = go.chip;
    assign go_write      = go.word;
    assign go_buf_load   = go.load;
    assign go_multi      = go.multi;
    assign go_lock_set   = go.lset;
    assign go_lock_clr   = go.lclr;
    assign go_suspend    = go.susp;
    assign go_resume     = go.resume;
endmodule

// File: rtl/fcs_checker.sv
// Assertion checker for flash_cmd_seq, attached by bind. Observes ports only.
module fcs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_ok,
    input logic [1:0] rd_mode,
    input logic [7:0] status,
    input logic       go_blk_erase,
    input logic       go_chip_erase,
    input logic       go_write,
    input logic       go_buf_load,
    input logic       go_multi,
    input logic       go_lock_set,
    input logic       go_lock_clr,
    input logic       go_suspend,
    input logic       go_resume
);
    logic [8:0] go_v;
    assign go_v = {go_blk_erase, go_chip_erase, go_write, go_buf_load, go_multi,
                   go_lock_set, go_lock_clr, go_suspend, go_resume};

    a_r13_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(go_v));

    a_r13_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (go_v != 9'd0) |=> (go_v == 9'd0));

    a_r4_status_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (go_blk_erase || go_chip_erase || go_write || go_multi) |-> rd_mode == 2'd3);

    a_r8_suspend_flag: assert property (@(posedge clk) disable iff (!rst_n)
        go_suspend |-> status[6]);

    a_r8_resume_from_susp: assert property (@(posedge clk) disable iff (!rst_n)
        go_resume |-> ($past(status[6]) && !status[6]));

    a_r9_clear_needs_wp: assert property (@(posedge clk) disable iff (!rst_n)
        go_lock_clr |-> $past(wp_ok));
endmodule

bind flash_cmd_seq fcs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wp_ok(wp_ok), .rd_mode(rd_mode), .status(status),
    .go_blk_erase(go_blk_erase), .go_chip_erase(go_chip_erase),
    .go_write(go_write), .go_buf_load(go_buf_load), .go_multi(go_multi),
    .go_lock_set(go_lock_set), .go_lock_clr(go_lock_clr),
    .go_suspend(go_suspend), .go_resume(go_resume)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we_n = 1'b1, ce_n = 1'b1;
    logic [20:0] addr = '0;
    logic [7:0]  data = '0;
    logic        wp = 1'b0, busy = 1'b0;
    logic [1:0]  rd_mode, busy_cfg;
    logic [7:0]  status, cmd_data;
    logic [20:0] cmd_addr;
    logic        g_be, g_ce, g_wr, g_ld, g_mu, g_ls, g_lc, g_su, g_re;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference state
    int          e_st = 0, e_cnt = 0;
    bit          e_ref = 0;
    logic [1:0]  e_mode = 0, e_cfg = 0;
    bit          e_ee = 0, e_ep = 0, e_ex = 0, e_susp = 0;
    logic [31:0] e_locks = '0;
    logic [20:0] e_caddr = '0;
    logic [7:0]  e_cdata = '0;

    always #4 clk = ~clk;   // 125 MHz

    flash_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .bus_we_n(we_n), .bus_ce_n(ce_n),
        .bus_addr(addr), .bus_data(data), .wp_ok(wp), .eng_busy(busy),
        .rd_mode(rd_mode), .status(status), .busy_cfg(busy_cfg),
        .go_blk_erase(g_be), .go_chip_erase(g_ce), .go_write(g_wr),
        .go_buf_load(g_ld), .go_multi(g_mu), .go_lock_set(g_ls),
        .go_lock_clr(g_lc), .go_suspend(g_su), .go_resume(g_re),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    function automatic logic [7:0] exp_status();
        return {~busy, e_susp, e_ee, e_ep, 2'b00, e_ex, 1'b0};
    endfunction

    // Reference model of one completed bus write; returns expected pulses.
    task automatic model(input logic [20:0] a, input logic [7:0] d,
                         output logic [8:0] eg, output string tag);
        bit blocked;
        bit abort;
        blocked = e_locks[a[20:16]] && !wp;
        abort = 0;
        eg = '0;
        tag = "R2";
        case (e_st)
            0: case (d)
                8'hFF: e_mode = 0;
                8'h90: e_mode = 1;
                8'h98: e_mode = 2;
                8'h70: e_mode = 3;
                8'h50: begin e_ee = 0; e_ep = 0; e_ex = 0; tag = "R3"; end
                8'h20: begin e_st = 1; e_mode = 3; tag = "R4"; end
                8'h30: begin e_st = 2; e_mode = 3; tag = "R5"; end
                8'h40, 8'h10: begin e_st = 3; e_mode = 3; tag = "R6"; end
                8'hE8: begin e_st = 4; e_mode = 3; tag = "R7"; end
                8'h60: begin e_st = 7; e_mode = 3; tag = "R9"; end
                8'hB8: begin e_st = 8; tag = "R12"; end
                8'hB0: begin tag = "R8";
                    if (busy && !e_susp) begin eg[1] = 1; e_susp = 1; e_mode = 3; end
                end
                8'hD0: begin tag = "R8";
                    if (e_susp) begin eg[0] = 1; e_susp = 0; e_mode = 3; end
                end
                default: ;
            endcase
            1: begin e_st = 0; tag = "R4";
                if (d != 8'hD0) abort = 1;
                else if (blocked) begin e_ee = 1; e_ex = 1; tag = "R10"; end
                else begin eg[8] = 1; e_caddr = a; end
            end
            2: begin e_st = 0; tag = "R5";
                if (d != 8'hD0) abort = 1;
                else if (e_locks != 0 && !wp) begin e_ee = 1; e_ex = 1; end
                else eg[7] = 1;
            end
            3: begin e_st = 0; tag = "R6";
                if (blocked) begin e_ep = 1; e_ex = 1; tag = "R10"; end
                else begin eg[6] = 1; e_caddr = a; e_cdata = d; end
            end
            4: begin tag = "R7";
                if (d == 0 || d > 16) begin e_st = 0; abort = 1; end
                else begin e_st = 5; e_cnt = d; e_ref = 0; end
            end
            5: begin tag = "R7"; eg[5] = 1; e_caddr = a; e_cdata = d;
                if (blocked) e_ref = 1;
                e_cnt--;
                if (e_cnt == 0) e_st = 6;
            end
            6: begin e_st = 0; tag = "R7";
                if (d != 8'hD0) abort = 1;
                else if (e_ref) begin e_ep = 1; e_ex = 1; tag = "R10"; end
                else eg[4] = 1;
            end
            7: begin e_st = 0; tag = "R9";
                if (d == 8'h01) begin eg[3] = 1; e_caddr = a; e_locks[a[20:16]] = 1; end
                else if (d == 8'hD0) begin
                    if (wp) begin eg[2] = 1; e_locks = '0; end
                    else begin e_ee = 1; e_ex = 1; end
                end else abort = 1;
            end
            default: begin e_st = 0; tag = "R12";
                if (d < 4) e_cfg = d[1:0];
                else abort = 1;
            end
        endcase
        if (abort) begin e_ee = 1; e_ep = 1; e_mode = 3; tag = "R11"; end
    endtask

    task automatic compare(input logic [8:0] eg, input string tag);
        logic [8:0] ag;
        bit bad;
        ag = {g_be, g_ce, g_wr, g_ld, g_mu, g_ls, g_lc, g_su, g_re};
        bad = (rd_mode !== e_mode) || (status !== exp_status()) ||
              (busy_cfg !== e_cfg) || (ag !== eg);
        if ((eg[8] | eg[6] | eg[5] | eg[3]) && cmd_addr !== e_caddr) bad = 1;
        if ((eg[6] | eg[5]) && cmd_data !== e_cdata) bad = 1;
        checks++;
        if (bad) begin
            fails++;
            $display("FAIL %s: mode %0d exp %0d, status %h exp %h, cfg %0d exp %0d, go %b exp %b, addr %h exp %h, data %h exp %h",
                     tag, rd_mode, e_mode, status, exp_status(), busy_cfg, e_cfg,
                     ag, eg, cmd_addr, e_caddr, cmd_data, e_cdata);
        end
    endtask

    // One bus write (R13): both strobes low for 'hold' clocks, then one rises.
    task automatic bus_write(input logic [20:0] a, input logic [7:0] d,
                             input int hold, input bit ce_first);
        logic [8:0] eg;
        string tag;
        we_n = 0; ce_n = 0; addr = a; data = d;
        repeat (hold) @(negedge clk);
        if (ce_first) ce_n = 1; else we_n = 1;
        @(negedge clk);
        we_n = 1; ce_n = 1;
        @(negedge clk);
        model(a, d, eg, tag);
        compare(eg, tag);
    endtask

    task automatic wr(input logic [20:0] a, input logic [7:0] d);
        bus_write(a, d, 1, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got hung exp done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        compare(9'd0, "R1");

        // R2 read modes and an undefined code
        wr(21'h0, 8'h90); wr(21'h0, 8'h98); wr(21'h0, 8'h70);
        wr(21'h0, 8'hFF); wr(21'h0, 8'h42);
        // R4 block erase, R5 chip erase
        wr(21'h1_2345, 8'h20); wr(21'h0A_0010, 8'hD0);
        wr(21'h0, 8'h30); wr(21'h0, 8'hD0);
        // R6 both setup codes, data equal to a command code
        wr(21'h0, 8'h40); wr(21'h03_0004, 8'h5A);
        wr(21'h0, 8'h10); wr(21'h04_0000, 8'hD0);
        // R7 buffered write, count 3, then counts 0 and 17
        wr(21'h0, 8'hE8); wr(21'h0, 8'd3);
        wr(21'h05_0001, 8'h11); wr(21'h05_0002, 8'h22); wr(21'h05_0003, 8'h33);
        wr(21'h0, 8'hD0);
        wr(21'h0, 8'hE8); wr(21'h0, 8'd0);
        wr(21'h0, 8'h50);
        wr(21'h0, 8'hE8); wr(21'h0, 8'd17);
        wr(21'h0, 8'h50);
        // R9/R10 lock block 6, refused and accepted operations
        wr(21'h0, 8'h60); wr(21'h06_0000, 8'h01);
        wp = 0; wr(21'h0, 8'h40); wr(21'h06_0100, 8'h77);
        wr(21'h0, 8'h20); wr(21'h06_0000, 8'hD0);
        wr(21'h0, 8'h30); wr(21'h0, 8'hD0);
        wr(21'h0, 8'h50);
        wp = 1; wr(21'h0, 8'h40); wr(21'h06_0100, 8'h77);
        wp = 0; wr(21'h0, 8'h60); wr(21'h0, 8'hD0);
        wp = 1; wr(21'h0, 8'h60); wr(21'h0, 8'hD0);
        wp = 0; wr(21'h0, 8'h20); wr(21'h06_0000, 8'hD0);
        // R11 bad confirm
        wr(21'h0, 8'h50); wr(21'h0, 8'hFF);
        wr(21'h0, 8'h20); wr(21'h0, 8'h55);
        // R12 busy config
        wr(21'h0, 8'h50); wr(21'h0, 8'hFF);
        wr(21'h0, 8'hB8); wr(21'h0, 8'h02);
        wr(21'h0, 8'hB8); wr(21'h0, 8'h07);
        // R8 suspend/resume
        wr(21'h0, 8'hB0);
        busy = 1; wr(21'h0, 8'hB0); wr(21'h0, 8'hB0);
        wr(21'h0, 8'hD0); busy = 0;
        // R13 chip-enable rises first; long low phase with changing address
        bus_write(21'h0, 8'h40, 1, 1);
        bus_write(21'h07_0007, 8'h99, 2, 1);
        we_n = 0; ce_n = 0; addr = 21'h1F_FFFF; data = 8'h40;
        @(negedge clk);
        bus_write(21'h0, 8'h10, 3, 0);
        we_n = 0; ce_n = 0; addr = 21'h1F_0000; data = 8'hEE;
        @(negedge clk);
        bus_write(21'h08_0008, 8'h3C, 2, 0);

        // random stream covering R2-R12
        for (int i = 0; i < 600; i++) begin
            logic [7:0] d;
            int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0, 1, 2: begin
                    case ($urandom_range(0, 14))
                        0: d = 8'hFF; 1: d = 8'h90; 2: d = 8'h98; 3: d = 8'h70;
                        4: d = 8'h50; 5: d = 8'h20; 6: d = 8'h30; 7: d = 8'h40;
                        8: d = 8'h10; 9: d = 8'hE8; 10: d = 8'hB0; 11: d = 8'hD0;
                        12: d = 8'h60; 13: d = 8'hB8; default: d = 8'h01;
                    endcase
                end
                3, 4: d = 8'hD0;
                5, 6: d = 8'($urandom_range(0, 5));
                default: d = 8'($urandom);
            endcase
            wp   = ($urandom_range(0, 3) == 0);
            busy = ($urandom_range(0, 2) == 0);
            wr(21'($urandom), d);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule